// File: doc/BRIEF.md
# Paced PCM Sample Player

This block plays back a stretch of 8-bit sample memory through a 7-bit DAC register at a fixed rate. Software programs a start pointer and a length through a small register window. It then sets an enable bit. From that point a countdown driven by CPU-cycle ticks paces the engine. Each time the countdown expires, the engine fetches one byte from a 32 KiB region of a banked memory window. It halves the byte and strobes the result into the DAC. When the programmed length is used up, the engine stops itself and raises a sticky interrupt flag.

The register window is only live while a gate bit in a separate mode register is set. When the gate is open, a write that carries the enable bit is passed downstream with that bit cleared. A read of the control/status offset then shows the interrupt flag in bit 7 in place of the downstream value. The two low bits of the mode register, inverted, select which quarter of the 64 KiB fetch space holds the samples.

The memory and the DAC lie outside the block. The memory is reached through a registered request that is answered with a valid pulse one cycle later. The DAC sees a one-cycle write strobe with a 7-bit value.

Top module: `pcm_player`

## Requirements
- R1: While bit 4 of the mode register (offset 0x30) is 0, writes to offsets 0x12, 0x13 and 0x15 change nothing: no fetch starts, and the interrupt flag and the enable keep their values.
- R2: A gated write of D to offset 0x12 sets the sample pointer to D*64.
- R3: A gated write of D to offset 0x13 sets the length so that the following playback performs exactly D*16+1 fetches before stopping.
- R4: A gated write to offset 0x15 sets the enable from data bit 4, clears the interrupt flag, and (when enabling) restarts the pacing countdown at the full period.
- R5: `fwd_wdata` equals `reg_wdata`, except that for a gated write to 0x15 bit 4 is forced to 0.
- R6: While enabled, consecutive fetch requests are separated by exactly PACE_PERIOD cycles in which `cpu_tick` was high.
- R7: `mem_addr` is the 15-bit pointer OR-ed with the inverted mode bits [1:0] placed at address bits [15:14].
- R8: Every memory response produces one `dac_wr` strobe in the next cycle, with `dac_data` equal to the fetched byte shifted right by 1.
- R9: After each completed fetch the pointer advances by one and wraps from 0x7FFF to 0x0000.
- R10: The expiry that finds the length exhausted performs no fetch. It clears the enable and sets `irq`, which stays high until a gated write to 0x15.
- R11: With the gate open and `reg_addr` = 0x15, `status_out` is `status_in` with bit 7 replaced by the interrupt flag; otherwise `status_out` equals `status_in`.
- R12: After reset the engine is idle: `irq`, `mem_req` and `dac_wr` are 0 and the gate is closed.

Reset value of the pacing countdown is PACE_PERIOD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One CPU cycle has elapsed |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset for writes and status reads |
| reg_wdata | input | 8 | Register write data |
| fwd_wdata | output | 8 | Write data forwarded downstream |
| status_in | input | 8 | Downstream status byte |
| status_out | output | 8 | Status byte after the interrupt merge |
| mem_req | output | 1 | One-cycle sample fetch request |
| mem_addr | output | 16 | Sample fetch address |
| mem_valid | input | 1 | Fetch response valid |
| mem_rdata | input | 8 | Fetched sample byte |
| dac_wr | output | 1 | DAC write strobe |
| dac_data | output | 7 | DAC value |
| irq | output | 1 | Sticky end-of-sample interrupt |

## Verification
The bench runs a small sweep over all four window selections and several lengths and start pointers. It checks every fetch address and DAC value against an arithmetic model. An off-by-one in the length arithmetic would show up as one fetch too many or too few. A wrong pacing reload would change the tick distance between requests; that distance is also measured with ticks held low every other cycle. Long back-to-back playbacks without reloading the pointer push it across 0x7FFF, where a wrong wrap would leak into the window bits. Gate-closed writes, interrupt clearing and a mid-play disable check that a gate leak or a non-sticky flag is caught at the ports.

// File: rtl/pcm_player_pkg.sv
package pcm_player_pkg;

  localparam int OFS_W  = 6;
  localparam int PTR_W  = 15;
  localparam int LEN_W  = 13;
  localparam int MADR_W = 16;
  localparam int DAC_W  = 7;

  localparam logic [OFS_W-1:0] OFS_START = 6'h12;
  localparam logic [OFS_W-1:0] OFS_LEN   = 6'h13;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 6'h15;
  localparam logic [OFS_W-1:0] OFS_MODE  = 6'h30;

  localparam int GATE_BIT = 4;
  localparam int EN_BIT   = 4;
  localparam int FLAG_BIT = 7;

  // start pointer: byte value scaled by 64
  function automatic logic [PTR_W-1:0] start_of(input logic [7:0] d);
    return {1'b0, d, 6'b000000};
  endfunction

  // length: byte value scaled by 16 plus one
  function automatic logic signed [LEN_W-1:0] len_of(input logic [7:0] d);
    logic [LEN_W-1:0] base;
    base = {1'b0, d, 4'b0000};
    return $signed(base + 13'd1);
  endfunction

  // fetch address: inverted window bits over the pointer's upper bits
  function automatic logic [MADR_W-1:0] window_addr(input logic [PTR_W-1:0] p,
                                                    input logic [1:0] w);
    return {~w[1], (~w[0]) | p[PTR_W-1], p[PTR_W-2:0]};
  endfunction

  function automatic logic [DAC_W-1:0] dac_scale(input logic [7:0] b);
    return b[7:1];
  endfunction

endpackage

// File: rtl/pcm_regs.sv
module pcm_regs
  import pcm_player_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic [7:0]       status_in,
  input  logic             irq_flag,
  output logic [7:0]       fwd_wdata,
  output logic [7:0]       status_out,
  output logic             mode_on,
  output logic [1:0]       win,
  output logic             ld_start,
  output logic             ld_len,
  output logic             wr_ctrl
);

  logic [7:0] mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 8'h00;
    else if (reg_wr && reg_addr == OFS_MODE) mode_q <= reg_wdata;
  end

  assign mode_on = mode_q[GATE_BIT];
  assign win     = mode_q[1:0];

  assign ld_start = reg_wr && mode_on && (reg_addr == OFS_START);
  assign ld_len   = reg_wr && mode_on && (reg_addr == OFS_LEN);
  assign wr_ctrl  = reg_wr && mode_on && (reg_addr == OFS_CTRL);

  always_comb begin
    fwd_wdata = reg_wdata;
    if (wr_ctrl) fwd_wdata[EN_BIT] = 1'b0;
  end

  always_comb begin
    status_out = status_in;
    if (mode_on && reg_addr == OFS_CTRL) status_out[FLAG_BIT] = irq_flag;
  end

endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer #(
  parameter int PERIOD = 225
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic restart,
  output logic expire
);

  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(PERIOD);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt;

  assign expire = run && tick && !restart && (cnt <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= RELOAD;
    else if (restart)        cnt <= RELOAD;
    else if (run && tick)    cnt <= (cnt <= ONE) ? RELOAD : cnt - ONE;
  end

endmodule

// File: rtl/pcm_fetch.sv
module pcm_fetch
  import pcm_player_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        wdata,
  input  logic              ld_start,
  input  logic              ld_len,
  input  logic              wr_ctrl,
  input  logic [1:0]        win,
  input  logic              expire,
  input  logic              mem_valid,
  input  logic [7:0]        mem_rdata,
  output logic              play_en,
  output logic              irq_flag,
  output logic              underflow,
  output logic              fetch_start,
  output logic              mem_req,
  output logic [MADR_W-1:0] mem_addr,
  output logic              dac_wr,
  output logic [DAC_W-1:0]  dac_data
);

  logic [PTR_W-1:0]        ptr;
  logic signed [LEN_W-1:0] len;
  logic signed [LEN_W-1:0] len_dec;

  assign len_dec     = len - 13'sd1;
  assign underflow   = expire && len_dec[LEN_W-1];
  assign fetch_start = expire && !len_dec[LEN_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      len      <= '0;
      play_en  <= 1'b0;
      irq_flag <= 1'b0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      dac_wr   <= 1'b0;
      dac_data <= '0;
    end else begin
      mem_req <= 1'b0;
      dac_wr  <= 1'b0;

      if (ld_start)       ptr <= start_of(wdata);
      else if (mem_valid) ptr <= ptr + 1'b1;

      if (ld_len)         len <= len_of(wdata);
      else if (expire)    len <= len_dec;

      if (wr_ctrl) begin
        play_en  <= wdata[EN_BIT];
        irq_flag <= 1'b0;
      end else if (underflow) begin
        play_en  <= 1'b0;
        irq_flag <= 1'b1;
      end

      if (fetch_start) begin
        mem_req  <= 1'b1;
        mem_addr <= window_addr(ptr, win);
      end

      if (mem_valid) begin
        dac_wr   <= 1'b1;
        dac_data <= dac_scale(mem_rdata);
      end
    end
  end

endmodule

// File: rtl/pcm_player.sv
module pcm_player
  import pcm_player_pkg::*;
#(
  parameter int PACE_PERIOD = 225
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_tick,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        fwd_wdata,
  input  logic [7:0]        status_in,
  output logic [7:0]        status_out,
  output logic              mem_req,
  output logic [MADR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_rdata,
  output logic              dac_wr,
  output logic [DAC_W-1:0]  dac_data,
  output logic              irq
);

  logic       mode_on;
  logic [1:0] win;
  logic       ld_start, ld_len, wr_ctrl;
  logic       restart, pace_expire;
  logic       play_en, len_underflow, fetch_start;

  pcm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status_in(status_in), .irq_flag(irq),
    .fwd_wdata(fwd_wdata), .status_out(status_out), .mode_on(mode_on),
    .win(win), .ld_start(ld_start), .ld_len(ld_len), .wr_ctrl(wr_ctrl)
  );

  assign restart = wr_ctrl && reg_wdata[EN_BIT];

  pcm_pacer #(.PERIOD(PACE_PERIOD)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(play_en), .tick(cpu_tick),
    .restart(restart), .expire(pace_expire)
  );

  pcm_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata), .ld_start(ld_start),
    .ld_len(ld_len), .wr_ctrl(wr_ctrl), .win(win), .expire(pace_expire),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .play_en(play_en),
    .irq_flag(irq), .underflow(len_underflow), .fetch_start(fetch_start),
    .mem_req(mem_req), .mem_addr(mem_addr), .dac_wr(dac_wr), .dac_data(dac_data)
  );

endmodule

// File: rtl/pcm_player_chk.sv
module pcm_player_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [5:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] fwd_wdata,
  input logic [7:0] status_in,
  input logic [7:0] status_out,
  input logic       mode_on,
  input logic       wr_ctrl,
  input logic       play_en,
  input logic       pace_expire,
  input logic       len_underflow,
  input logic       mem_req,
  input logic       mem_valid,
  input logic [7:0] mem_rdata,
  input logic       dac_wr,
  input logic [6:0] dac_data,
  input logic       irq
);

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !mode_on && !len_underflow |=> irq == $past(irq) && play_en == $past(play_en));

  p_ctl_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !irq);

  p_fwd_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr != 6'h15 |-> fwd_wdata == reg_wdata);

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_expire_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pace_expire |-> play_en);

  p_dac_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |=> dac_wr && dac_data == $past(mem_rdata[7:1]));

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    len_underflow && !wr_ctrl |=> irq && !play_en);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !wr_ctrl |=> irq);

  p_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_on && reg_addr == 6'h15 |-> status_out[7] == irq && status_out[6:0] == status_in[6:0]);

endmodule

bind pcm_player pcm_player_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fwd_wdata(fwd_wdata), .status_in(status_in),
  .status_out(status_out), .mode_on(mode_on), .wr_ctrl(wr_ctrl),
  .play_en(play_en), .pace_expire(pace_expire), .len_underflow(len_underflow),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
  .dac_wr(dac_wr), .dac_data(dac_data), .irq(irq)
);

// File: tb/sim_pcm_player.sv
module sim_pcm_player;

  localparam int CLK_PERIOD = 10;
  localparam int PACE       = 3;
  localparam int WDOG       = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_tick = 1'b1;
  logic       reg_wr;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, fwd_wdata, status_in, status_out, mem_rdata;
  logic       mem_req, mem_valid, dac_wr, irq;
  logic [15:0] mem_addr;
  logic [6:0]  dac_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int model_ptr = 0, win = 0, mode_model = 0;
  int nfetch = 0, tick_cnt = 0, pend_addr = 0;
  bit have_prev = 0, wrapped = 0, gap_mode = 0, done = 0, tick_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_player #(.PACE_PERIOD(PACE)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fwd_wdata(fwd_wdata),
    .status_in(status_in), .status_out(status_out), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .dac_wr(dac_wr), .dac_data(dac_data), .irq(irq)
  );

  function automatic int memf(input int a);
    return ((a & 255) ^ ((a >> 8) & 255) ^ ((a >> 3) & 255) ^ 8'h5A) & 255;
  endfunction

  // memory model: answers one cycle after the request
  always @(posedge clk) begin
    mem_valid <= mem_req;
    mem_rdata <= 8'(memf(int'(mem_addr)));
    tick_seen <= cpu_tick;
  end

  always @(negedge clk) cpu_tick = gap_mode ? ~cpu_tick : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      tick_cnt += int'(tick_seen);
      if (mem_req) begin
        int ea;
        ea = (model_ptr | ((win ^ 3) << 14)) & 16'hFFFF;
        chk(int'(mem_addr) == ea, "R2,R7 fetch address", int'(mem_addr), ea);
        if (have_prev) chk(tick_cnt == PACE, "R6 tick spacing", tick_cnt, PACE);
        tick_cnt = 0;
        have_prev = 1;
        pend_addr = int'(mem_addr);
      end
      if (dac_wr) begin
        chk(int'(dac_data) == (memf(pend_addr) >> 1), "R8 dac value", int'(dac_data), memf(pend_addr) >> 1);
        model_ptr = (model_ptr + 1) & 16'h7FFF;
        if (model_ptr == 0) wrapped = 1;
        nfetch++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<%0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    int ef;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    #1;
    ef = (a == 6'h15 && (mode_model & 8'h10) != 0) ? (int'(d) & 8'hEF) : int'(d);
    chk(int'(fwd_wdata) == ef, "R5 forwarded data", int'(fwd_wdata), ef);
    if (a == 6'h30) mode_model = int'(d);
    if (a == 6'h12 && (mode_model & 8'h10) != 0) model_ptr = int'(d) << 6;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic status_rd(input logic [7:0] sin, input int exp, input string req);
    @(negedge clk);
    reg_addr = 6'h15; status_in = sin;
    #1;
    chk(int'(status_out) == exp, req, int'(status_out), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic play(input int w, input int a, input int d, input bit load);
    int lim, n;
    wr(6'h30, 8'(8'h10 | w));
    win = w;
    if (load) wr(6'h12, 8'(a));
    wr(6'h13, 8'(d));
    nfetch = 0; have_prev = 0;
    wr(6'h15, 8'h10);
    chk(irq == 1'b0, "R4 enable write clears irq", int'(irq), 0);
    lim = 0;
    while (!irq && lim < 30000) begin @(negedge clk); lim++; end
    chk(irq == 1'b1, "R10 irq at end", int'(irq), 1);
    chk(nfetch == d * 16 + 1, "R3 fetch count", nfetch, d * 16 + 1);
    n = nfetch;
    idle(6 * PACE);
    chk(nfetch == n && irq, "R10 stopped and sticky", nfetch, n);
    status_rd(8'h41, 8'hC1, "R11 flag merged");
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 6'h15; reg_wdata = 8'h00; status_in = 8'h41;
    idle(3);
    #1;
    chk(irq == 1'b0 && mem_req == 1'b0 && dac_wr == 1'b0, "R12 reset outputs", int'({irq, mem_req, dac_wr}), 0);
    chk(status_out == 8'h41, "R12 gate closed after reset", int'(status_out), 8'h41);
    rst_n = 1'b1;
    idle(2);

    // gate closed: control writes do nothing
    wr(6'h13, 8'h00);
    wr(6'h15, 8'h10);
    idle(10 * PACE);
    chk(nfetch == 0 && irq == 1'b0, "R1 gate closed no playback", nfetch, 0);
    status_rd(8'hC1, 8'hC1, "R11 passthrough gate closed");

    // sweep window, length and start pointer
    for (int w = 0; w < 4; w++)
      for (int d = 0; d < 3; d++)
        play(w, (w * 37 + d * 11 + 5) & 255, d, 1'b1);

    // tick gaps: spacing counted in ticks
    gap_mode = 1;
    play(1, 8'h20, 1, 1'b1);
    gap_mode = 0;
    idle(2);

    // irq held while the gate is closed
    wr(6'h30, 8'h00);
    wr(6'h15, 8'h10);
    chk(irq == 1'b1, "R1 gated ctrl write keeps irq", int'(irq), 1);
    idle(5 * PACE);
    chk(nfetch == 17, "R1 gated enable starts nothing", nfetch, 17);
    status_rd(8'h00, 8'h00, "R11 passthrough gate closed");
    wr(6'h30, 8'h10);
    status_rd(8'h00, 8'h80, "R11 flag shown");
    wr(6'h15, 8'h00);
    chk(irq == 1'b0, "R4 ctrl write clears irq", int'(irq), 0);
    idle(10 * PACE);
    chk(irq == 1'b0 && nfetch == 17, "R4 disabled stays idle", nfetch, 17);

    // disable in mid-play
    begin
      int n, lim;
      win = 0;
      wr(6'h13, 8'h02);
      nfetch = 0; have_prev = 0;
      wr(6'h15, 8'h10);
      lim = 0;
      while (nfetch < 5 && lim < 1000) begin @(negedge clk); lim++; end
      wr(6'h15, 8'h00);
      n = nfetch;
      idle(12 * PACE);
      chk(nfetch - n <= 1 && nfetch < 33, "R4 disable stops fetching", nfetch, n);
      chk(irq == 1'b0, "R4 no irq after disable", int'(irq), 0);
    end

    // long runs without reloading the pointer: crosses 0x7FFF
    wrapped = 0;
    play(2, 8'hFF, 8'hFF, 1'b1);
    for (int k = 0; k < 4; k++) play(2, 0, 8'hFF, 1'b0);
    chk(wrapped == 1, "R9 pointer wrapped", int'(wrapped), 1);

    done = 1;
    summary();
    $finish;
  end

endmodule